// File: doc/BRIEF.md
# Multi-pipe warp instruction issue scheduler

This block sits at the front of a streaming core's execution stage. Each clock it looks at a set of warp slots. Every slot offers one candidate instruction, given as a valid flag, a 3-bit class code and a flag that marks an instruction with no register operands. The block picks at most one slot and sends its instruction to the execution pipe that matches the class.

Each pipe has a down-counter. The counter holds the pipe busy for a set number of cycles after it accepts an instruction. The FP32, INT32, FP64 and SFU pipes are half-rate, so they accept one instruction every two cycles. The memory and branch pipes can accept one instruction on every cycle. The tensor pipe stays occupied for four cycles.

Because some pipes are half-rate, instructions of different classes from different warps can fill alternate cycles. For example, one warp issuing FP32 and another issuing INT32 keep the issue port busy on every cycle. The tensor pipe has its own overlap rule. While it is occupied, only instructions with no register operands may issue. A tensor instruction also waits until no instruction with operands is still occupying a pipe. Slots are served round-robin, and the search starts at the slot after the one that issued last.

Top module: `warp_issue_sched`

## Requirements
- R1: The class code selects the pipe: 0 FP32, 1 INT32, 2 FP64, 3 memory, 4 SFU, 5 branch, 6 tensor. Code 7 is never issued. At most one instruction issues per cycle, and `issue_pipe` equals the class code of the issued slot.
- R2: While `rst` is high, `issue_valid` is 0, including the cycle after the reset edge. Reset clears every pipe counter and sets the round-robin start to slot 0, so the first issue after reset goes to the lowest eligible slot.
- R3: The FP32, INT32, FP64 and SFU pipes are not issued on the cycle that follows an issue to the same pipe.
- R4: The memory and branch pipes can accept an instruction on every cycle.
- R5: After a tensor issue, the tensor pipe accepts nothing on the next three cycles.
- R6: While the tensor pipe is occupied, only slots whose zero-operand flag is 1 may issue.
- R7: A tensor instruction is held while any pipe is occupied by an instruction that has register operands.
- R8: Among eligible slots, the one chosen is the first found when searching upward, with wrap-around, from the slot after the last issued one.
- R9: If any slot is eligible, an instruction issues that cycle. An instruction appears at the outputs one cycle after the inputs that caused it.
- R10: A slot offering only FP32 and another offering only INT32, both with operands, produce an issue on every cycle.
- R11: A slot whose valid flag is 0 is never selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_valid | input | NUM_WARPS | Per-slot candidate present |
| warp_cls | input | 3*NUM_WARPS | Per-slot class code, slot w at bits [3w+2:3w] |
| warp_zop | input | NUM_WARPS | Per-slot zero-register-operand flag |
| issue_valid | output | 1 | Registered issue strobe |
| issue_warp | output | clog2(NUM_WARPS) | Slot index of the issued instruction |
| issue_pipe | output | 3 | Target pipe (equal to the class code) |

## Verification
The bench drives the following patterns:
- **Single FP32 slot.** Shows that the issue port idles on every other cycle.
- **FP32 slot alongside an INT32 slot.** Must fill every cycle, which separates per-pipe occupancy from a global stall.
- **Several slots of one half-rate class.** Exposes the round-robin order without interference from other classes.
- **Memory-only slots.** Confirm that single-cycle pipes are never throttled.
- **Tensor slot beside an FP32 slot and a zero-operand branch slot.** Separates the hold placed on operand-carrying instructions from the pass given to zero-operand ones. An FP32 issue placed just ahead of the tensor instruction checks that the tensor instruction waits.
- **Seeded random mix.** Covers the remaining interactions. A bench occupancy model predicts every issue, and the bench separately checks pipe spacing against the actual issue history.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int CLS_W     = 3;
  localparam int NUM_PIPES = 7;
  localparam int CLS_CODES = 1 << CLS_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_FP32   = 3'd0,
    CLS_INT32  = 3'd1,
    CLS_FP64   = 3'd2,
    CLS_MEM    = 3'd3,
    CLS_SFU    = 3'd4,
    CLS_BRANCH = 3'd5,
    CLS_TENSOR = 3'd6
  } iclass_e;
endpackage

// File: rtl/issue_pipe_timer.sv
module issue_pipe_timer #(
  parameter int OCC = 2,
  localparam int CNT_W = (OCC > 1) ? $clog2(OCC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_opnd,
  output logic busy,
  output logic opnd_busy
);
  logic [CNT_W-1:0] count;
  logic             opnd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      opnd_q <= 1'b0;
    end else if (load) begin
      count  <= CNT_W'(OCC - 1);
      opnd_q <= load_opnd;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign busy      = (count != '0);
  assign opnd_busy = busy && opnd_q;

  // R3 R5
  load_when_free_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (count == '0));
endmodule

// File: rtl/issue_legality.sv
module issue_legality import issue_pkg::*; #(
  parameter int NUM_WARPS = 8
) (
  input  logic [NUM_WARPS-1:0]       warp_valid,
  input  logic [NUM_WARPS*CLS_W-1:0] warp_cls,
  input  logic [NUM_WARPS-1:0]       warp_zop,
  input  logic [NUM_PIPES-1:0]       pipe_busy,
  input  logic [NUM_PIPES-1:0]       opnd_busy,
  output logic [NUM_WARPS-1:0]       eligible
);
  localparam int PAD = CLS_CODES - NUM_PIPES;

  logic [CLS_CODES-1:0] busy_ext;
  logic                 tensor_busy;
  logic                 any_opnd;

  // unused codes map to a permanently busy pipe
  assign busy_ext    = {{PAD{1'b1}}, pipe_busy};
  assign tensor_busy = pipe_busy[CLS_TENSOR];
  assign any_opnd    = |opnd_busy;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic [CLS_W-1:0] cls;
    logic             free_pipe;
    logic             tensor_hold;
    logic             tensor_wait;

    always_comb begin
      cls         = warp_cls[w*CLS_W +: CLS_W];
      free_pipe   = !busy_ext[cls];
      tensor_hold = tensor_busy && !warp_zop[w];
      tensor_wait = (cls == CLS_TENSOR) && any_opnd;
      eligible[w] = warp_valid[w] && free_pipe && !tensor_hold && !tensor_wait;
    end
  end
endmodule

// File: rtl/issue_rr_pick.sv
module issue_rr_pick #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] start,
  output logic             pick_valid,
  output logic [IDX_W-1:0] pick_idx
);
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!pick_valid && req[(int'(start) + i) % N]) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'((int'(start) + i) % N);
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched import issue_pkg::*; #(
  parameter int NUM_WARPS  = 8,
  parameter int OCC_FP32   = 2,
  parameter int OCC_INT32  = 2,
  parameter int OCC_FP64   = 2,
  parameter int OCC_MEM    = 1,
  parameter int OCC_SFU    = 2,
  parameter int OCC_BRANCH = 1,
  parameter int OCC_TENSOR = 4,
  localparam int WIDX_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WARPS-1:0]       warp_valid,
  input  logic [NUM_WARPS*CLS_W-1:0] warp_cls,
  input  logic [NUM_WARPS-1:0]       warp_zop,
  output logic                       issue_valid,
  output logic [WIDX_W-1:0]          issue_warp,
  output logic [CLS_W-1:0]           issue_pipe
);
  function automatic int occ_of(input int p);
    case (p)
      0:       return OCC_FP32;
      1:       return OCC_INT32;
      2:       return OCC_FP64;
      3:       return OCC_MEM;
      4:       return OCC_SFU;
      5:       return OCC_BRANCH;
      default: return OCC_TENSOR;
    endcase
  endfunction

  function automatic logic [CLS_CODES-1:0] multi_mask();
    logic [CLS_CODES-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PIPES; p++) m[p] = (occ_of(p) > 1);
    return m;
  endfunction

  localparam logic [CLS_CODES-1:0] MULTI_CYC = multi_mask();

  logic [NUM_PIPES-1:0] pipe_busy;
  logic [NUM_PIPES-1:0] opnd_busy;
  logic [NUM_PIPES-1:0] pipe_load;
  logic [NUM_WARPS-1:0] eligible;
  logic                 sel_valid;
  logic [WIDX_W-1:0]    sel_idx;
  logic [CLS_W-1:0]     sel_cls;
  logic                 sel_zop;
  logic [WIDX_W-1:0]    rr_start;
  logic                 issue_zop;

  issue_legality #(.NUM_WARPS(NUM_WARPS)) u_legal (
    .warp_valid (warp_valid),
    .warp_cls   (warp_cls),
    .warp_zop   (warp_zop),
    .pipe_busy  (pipe_busy),
    .opnd_busy  (opnd_busy),
    .eligible   (eligible)
  );

  issue_rr_pick #(.N(NUM_WARPS)) u_pick (
    .req        (eligible),
    .start      (rr_start),
    .pick_valid (sel_valid),
    .pick_idx   (sel_idx)
  );

  assign sel_cls = warp_cls[int'(sel_idx)*CLS_W +: CLS_W];
  assign sel_zop = warp_zop[sel_idx];

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    assign pipe_load[p] = sel_valid && (sel_cls == CLS_W'(p));

    issue_pipe_timer #(.OCC(occ_of(p))) u_timer (
      .clk       (clk),
      .rst       (rst),
      .load      (pipe_load[p]),
      .load_opnd (!sel_zop),
      .busy      (pipe_busy[p]),
      .opnd_busy (opnd_busy[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_pipe  <= '0;
      issue_zop   <= 1'b0;
      rr_start    <= '0;
    end else begin
      issue_valid <= sel_valid;
      if (sel_valid) begin
        issue_warp <= sel_idx;
        issue_pipe <= sel_cls;
        issue_zop  <= sel_zop;
        rr_start   <= (int'(sel_idx) == NUM_WARPS - 1) ? '0 : sel_idx + 1'b1;
      end
    end
  end

  // R1
  pipe_code_chk: assert property (@(posedge clk) disable iff (rst)
    issue_valid |-> (issue_pipe != 3'd7));

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !issue_valid);

  // R3
  half_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && MULTI_CYC[issue_pipe]) |=>
      !(issue_valid && issue_pipe == $past(issue_pipe)));

  // R6
  tensor_zero_op_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_pipe == CLS_TENSOR && OCC_TENSOR > 1) |=>
      (!issue_valid || issue_zop));

  // R11
  pick_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (eligible[sel_idx] && warp_valid[sel_idx]));

  // R9
  work_conserve_chk: assert property (@(posedge clk) disable iff (rst)
    (|eligible) |-> sel_valid);
endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int NP = 7;

  logic clk = 1'b0;
  logic rst;
  logic [NW-1:0]   wv;
  logic [NW*3-1:0] wc;
  logic [NW-1:0]   wz;
  logic            issue_valid;
  logic [1:0]      issue_warp;
  logic [2:0]      issue_pipe;

  warp_issue_sched #(.NUM_WARPS(NW)) uut (
    .clk(clk), .rst(rst), .warp_valid(wv), .warp_cls(wc), .warp_zop(wz),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_pipe(issue_pipe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int occ [NP] = '{2, 2, 2, 1, 2, 1, 4};
  int mcnt [NP];
  bit mop  [NP];
  int mptr;
  bit exp_v;
  int exp_w, exp_p;
  bit snap_v [NW];
  bit snap_z [NW];
  int last_iss [NP];
  int cyc;
  int issued;
  bit rand_mode;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic bit slot_ok(input int w);
    int c;
    bit tbusy, anyop;
    c = int'(wc[w*3 +: 3]);
    tbusy = (mcnt[6] != 0);
    anyop = 0;
    for (int p = 0; p < NP; p++) if (mcnt[p] != 0 && mop[p]) anyop = 1;
    if (!wv[w] || c >= NP) return 0;
    if (mcnt[c] != 0) return 0;
    if (tbusy && !wz[w]) return 0;
    if (c == 6 && anyop) return 0;
    return 1;
  endfunction

  task automatic predict();
    exp_v = 0; exp_w = 0; exp_p = 0;
    for (int i = 0; i < NW; i++) begin
      int w;
      w = (mptr + i) % NW;
      if (!exp_v && slot_ok(w)) begin
        exp_v = 1; exp_w = w; exp_p = int'(wc[w*3 +: 3]);
      end
    end
    for (int w = 0; w < NW; w++) begin
      snap_v[w] = wv[w]; snap_z[w] = wz[w];
    end
  endtask

  task automatic commit();
    for (int p = 0; p < NP; p++) if (mcnt[p] != 0) mcnt[p]--;
    if (exp_v) begin
      mcnt[exp_p] = occ[exp_p] - 1;
      mop[exp_p]  = !snap_z[exp_w];
      mptr = (exp_w + 1) % NW;
    end
  endtask

  task automatic refill(input int w);
    int c;
    wv[w] = ($urandom % 5) != 0;
    c = $urandom % NP;
    wc[w*3 +: 3] = 3'(c);
    if (c == 5) wz[w] = ($urandom % 4) != 0;
    else        wz[w] = ($urandom % 8) == 0;
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    commit();
    @(negedge clk);
    cyc++;
    chk(issue_valid == exp_v, "R9 issue strobe", int'(issue_valid), int'(exp_v));
    if (issue_valid && exp_v) begin
      chk(int'(issue_warp) == exp_w, "R8 round-robin slot", int'(issue_warp), exp_w);
      chk(int'(issue_pipe) == exp_p, "R1 pipe equals class", int'(issue_pipe), exp_p);
    end
    if (issue_valid) begin
      int p;
      p = int'(issue_pipe);
      issued++;
      chk(snap_v[issue_warp], "R11 valid slot only", 0, 1);
      if (p < NP) begin
        chk(cyc - last_iss[p] >= occ[p], "R3 R4 R5 pipe spacing", cyc - last_iss[p], occ[p]);
        if (p != 6 && cyc - last_iss[6] < occ[6])
          chk(snap_z[issue_warp], "R6 zero-operand during tensor", 0, 1);
        last_iss[p] = cyc;
      end
      if (rand_mode) refill(int'(issue_warp));
    end
  endtask

  task automatic set_slot(input int w, input bit v, input int c, input bit z);
    wv[w] = v; wc[w*3 +: 3] = 3'(c); wz[w] = z;
  endtask

  task automatic drain();
    wv = '0;
    for (int i = 0; i < 6; i++) step();
  endtask

  int seed_val;

  initial begin
    seed_val = $urandom(32'd7315);
    rand_mode = 0; cyc = 0; issued = 0; mptr = 0;
    for (int p = 0; p < NP; p++) begin mcnt[p] = 0; mop[p] = 0; last_iss[p] = -100; end
    wv = '1; wc = '0; wz = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: valid FP32 slots present during reset, still no issue
    chk(issue_valid == 1'b0, "R2 quiet in reset", int'(issue_valid), 0);
    rst = 1'b0;
    wv = 4'b1110;
    step();
    // R2: pointer cleared, lowest eligible slot (1) first
    chk(issue_valid && issue_warp == 2'd1, "R2 first slot after reset", int'(issue_warp), 1);
    drain();

    // R3: one FP32 slot issues every other cycle
    set_slot(0, 1, 0, 0);
    issued = 0;
    for (int i = 0; i < 10; i++) step();
    chk(issued == 5, "R3 single FP32 rate", issued, 5);
    drain();

    // R10: FP32 slot plus INT32 slot fill every cycle
    set_slot(0, 1, 0, 0); set_slot(1, 1, 1, 0);
    issued = 0;
    for (int i = 0; i < 20; i++) step();
    chk(issued == 20, "R10 interleaved full rate", issued, 20);
    drain();

    // R8: four FP32 slots rotate
    for (int w = 0; w < NW; w++) set_slot(w, 1, 0, 0);
    issued = 0;
    for (int i = 0; i < 16; i++) step();
    chk(issued == 8, "R8 shared half-rate pipe", issued, 8);
    drain();

    // R4: memory-only slots every cycle
    set_slot(0, 1, 3, 0); set_slot(2, 1, 3, 0);
    issued = 0;
    for (int i = 0; i < 12; i++) step();
    chk(issued == 12, "R4 memory full rate", issued, 12);
    drain();

    // R6: tensor beside FP32 and zero-operand branch
    set_slot(0, 1, 6, 0); set_slot(1, 1, 0, 0); set_slot(2, 1, 5, 1);
    for (int i = 0; i < 30; i++) step();
    drain();

    // R7: FP32 just ahead of tensor makes tensor wait
    mptr = mptr; 
    set_slot(0, 1, 0, 0);
    step();
    set_slot(0, 0, 0, 0); set_slot(1, 1, 6, 0);
    for (int i = 0; i < 3; i++) step();
    drain();

    // R11: invalid slots carrying classes never issue
    for (int w = 0; w < NW; w++) set_slot(w, 0, 3, 1);
    issued = 0;
    for (int i = 0; i < 6; i++) step();
    chk(issued == 0, "R11 no valid slots", issued, 0);

    // random mix
    rand_mode = 1;
    for (int w = 0; w < NW; w++) refill(w);
    for (int i = 0; i < 3000; i++) step();

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule